// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This unit holds the interrupt-side state of an SD host controller: a raw event status word, an interrupt mask, a global interrupt enable, and a status word that carries the card-present flag. It drives one level interrupt line that is high while the global enable is on and any raw event is unmasked. Software reaches its state through a word-addressed register port. Writes to the raw status and status registers clear bits, one bit per 1 written.

Three hardware sources feed events into the unit. Card insertion and card removal set flags that exclude each other. The data path reports each chunk of moved bytes. The unit counts down from a programmed byte total, stops at zero, and raises a data-done event whenever a chunk leaves the count at zero.

Top module: `sdh_irq_stat_top`

## Requirements
- R1: `irq` is high exactly when control bit 4 (interrupt enable) is 1 and raw status AND mask is nonzero. It follows mask, enable and status in the same cycle that their registers change.
- R2: Reading address 2 returns raw status AND mask. Reading address 3 returns the raw status without the mask.
- R3: Writing address 3 clears every raw status bit written as 1 and leaves every other bit as it was.
- R4: A card-insert pulse sets raw bit 30, clears raw bit 31 and sets status bit 8 (card present). A card-remove pulse sets raw bit 31, clears raw bit 30 and clears status bit 8. Bits 30 and 31 are never both set.
- R5: Writing address 5 stores the byte total, which reads back at address 5. The same write loads the remaining-bytes counter with that value, and the counter reads at address 6.
- R6: A transfer pulse subtracts `xfer_bytes` from the counter and stops at zero. If the result is zero, raw bit 3 (data done) is set.
- R7: Writing address 4 clears every status bit written as 1 and leaves every other bit as it was.
- R8: A synchronous reset clears control, mask, raw status, status, byte total and counter, so `irq` is 0.
- R9: Priority rules for events in the same cycle:
  - A hardware set of a raw bit wins over a software clear of that bit.
  - When insert and remove arrive together, remove wins.
  - A byte-total write wins over a transfer pulse, and that pulse is dropped.
- R10: Writes to address 2 (masked status) and address 6 (remaining count) change no state. Address 0 holds control and address 1 holds the mask, and both read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| card_in | input | 1 | Card insertion event pulse |
| card_out | input | 1 | Card removal event pulse |
| xfer_valid | input | 1 | Data path moved bytes this cycle |
| xfer_bytes | input | CNT_W | Number of bytes moved |
| irq | output | 1 | Interrupt request level |

## Verification
A wrong raw status or mask bit changes `irq` and both status reads in the same cycle it lands, so a read right after each stimulus exposes it. A miscounted remaining total reads wrong at address 6 right after the transfer. It also raises data done one chunk too early or too late, or never. The priority cases are checked by driving both sources into the same clock edge and reading the result on the next cycle.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_MASK   = 3'd1,
    ADR_MSTAT  = 3'd2,
    ADR_RAW    = 3'd3,
    ADR_STAT   = 3'd4,
    ADR_BCNT   = 3'd5,
    ADR_REMAIN = 3'd6
  } sdh_adr_e;

  localparam int BIT_IRQ_EN  = 4;
  localparam int BIT_DONE    = 3;
  localparam int BIT_CIN     = 30;
  localparam int BIT_COUT    = 31;
  localparam int BIT_PRESENT = 8;

endpackage

// File: rtl/sdh_ctrl_regs.sv
module sdh_ctrl_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              irq_en
);
  import sdh_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data;
      if (wr_mask) mask_q <= wr_data;
    end
  end

  assign irq_en = ctrl_q[BIT_IRQ_EN];

endmodule

// File: rtl/sdh_xfer_cnt.sv
module sdh_xfer_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             xfer_valid,
  input  logic [CNT_W-1:0] xfer_bytes,
  output logic [CNT_W-1:0] bcnt_q,
  output logic [CNT_W-1:0] remain_q,
  output logic             done_evt
);

  function automatic logic [CNT_W-1:0] sat_sub(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (b >= a) ? '0 : (a - b);
  endfunction

  logic             take_xfer;
  logic [CNT_W-1:0] after_xfer;

  assign take_xfer  = xfer_valid && !load;
  assign after_xfer = sat_sub(remain_q, xfer_bytes);
  assign done_evt   = take_xfer && (after_xfer == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt_q   <= '0;
      remain_q <= '0;
    end else if (load) begin
      bcnt_q   <= load_val;
      remain_q <= load_val;
    end else if (take_xfer) begin
      remain_q <= after_xfer;
    end
  end

endmodule

// File: rtl/sdh_raw_stat.sv
module sdh_raw_stat #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              card_in,
  input  logic              card_out,
  input  logic              done_evt,
  input  logic              clr_raw,
  input  logic              clr_stat,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] raw_q,
  output logic [DATA_W-1:0] stat_q
);
  import sdh_irq_pkg::*;

  function automatic logic [DATA_W-1:0] w1c(input logic [DATA_W-1:0] cur,
                                            input logic [DATA_W-1:0] ones,
                                            input logic             en);
    return en ? (cur & ~ones) : cur;
  endfunction

  logic [DATA_W-1:0] raw_nx, stat_nx;

  always_comb begin
    raw_nx  = w1c(raw_q, wr_data, clr_raw);
    stat_nx = w1c(stat_q, wr_data, clr_stat);
    if (card_out) begin
      raw_nx[BIT_COUT]     = 1'b1;
      raw_nx[BIT_CIN]      = 1'b0;
      stat_nx[BIT_PRESENT] = 1'b0;
    end else if (card_in) begin
      raw_nx[BIT_CIN]      = 1'b1;
      raw_nx[BIT_COUT]     = 1'b0;
      stat_nx[BIT_PRESENT] = 1'b1;
    end
    if (done_evt) raw_nx[BIT_DONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      stat_q <= '0;
    end else begin
      raw_q  <= raw_nx;
      stat_q <= stat_nx;
    end
  end

endmodule

// File: rtl/sdh_irq_stat_top.sv
module sdh_irq_stat_top #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              card_in,
  input  logic              card_out,
  input  logic              xfer_valid,
  input  logic [CNT_W-1:0]  xfer_bytes,
  output logic              irq
);
  import sdh_irq_pkg::*;

  logic [DATA_W-1:0] ctrl_q, mask_q, raw_q, stat_q, masked;
  logic [CNT_W-1:0]  bcnt_q, remain_q;
  logic              irq_en, done_evt;
  logic              wr_ctrl, wr_mask, clr_raw, clr_stat, load_evt;

  assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
  assign wr_mask  = wr_en && (wr_addr == ADR_MASK);
  assign clr_raw  = wr_en && (wr_addr == ADR_RAW);
  assign clr_stat = wr_en && (wr_addr == ADR_STAT);
  assign load_evt = wr_en && (wr_addr == ADR_BCNT);

  sdh_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .mask_q(mask_q), .irq_en(irq_en)
  );

  sdh_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_evt), .load_val(wr_data[CNT_W-1:0]),
    .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes),
    .bcnt_q(bcnt_q), .remain_q(remain_q), .done_evt(done_evt)
  );

  sdh_raw_stat #(.DATA_W(DATA_W)) u_raw (
    .clk(clk), .rst(rst), .card_in(card_in), .card_out(card_out),
    .done_evt(done_evt), .clr_raw(clr_raw), .clr_stat(clr_stat),
    .wr_data(wr_data), .raw_q(raw_q), .stat_q(stat_q)
  );

  assign masked = raw_q & mask_q;
  assign irq    = irq_en && (masked != '0);

  always_comb begin
    case (rd_addr)
      ADR_CTRL:   rd_data = ctrl_q;
      ADR_MASK:   rd_data = mask_q;
      ADR_MSTAT:  rd_data = masked;
      ADR_RAW:    rd_data = raw_q;
      ADR_STAT:   rd_data = stat_q;
      ADR_BCNT:   rd_data = DATA_W'(bcnt_q);
      ADR_REMAIN: rd_data = DATA_W'(remain_q);
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/sdh_irq_chk.sv
module sdh_irq_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              card_in,
  input logic              card_out,
  input logic              xfer_valid,
  input logic [CNT_W-1:0]  xfer_bytes,
  input logic              irq,
  input logic              irq_en,
  input logic [DATA_W-1:0] raw_q,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] stat_q,
  input logic [CNT_W-1:0]  remain_q
);
  import sdh_irq_pkg::*;

  logic bcnt_wr, raw_wr;
  assign bcnt_wr = wr_en && (wr_addr == ADR_BCNT);
  assign raw_wr  = wr_en && (wr_addr == ADR_RAW);

  // R1
  assert_irq_needs_cause_R1: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_en && ((raw_q & mask_q) != '0)));
  assert_irq_off_R1: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq);

  // R3
  assert_w1c_raw_R3: assert property (@(posedge clk) disable iff (rst)
    (raw_wr && !card_in && !card_out && !xfer_valid) |=> ((raw_q & $past(wr_data)) == '0));

  // R4
  assert_card_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(raw_q[BIT_CIN] && raw_q[BIT_COUT]));
  assert_insert_R4: assert property (@(posedge clk) disable iff (rst)
    (card_in && !card_out) |=> (raw_q[BIT_CIN] && stat_q[BIT_PRESENT]));

  // R5
  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    bcnt_wr |=> (remain_q == $past(wr_data[CNT_W-1:0])));

  // R6
  assert_sat_done_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !bcnt_wr && (xfer_bytes >= remain_q)) |=> (remain_q == '0 && raw_q[BIT_DONE]));

  // R10
  assert_ro_remain_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_REMAIN && !xfer_valid) |=> $stable(remain_q));

endmodule

bind sdh_irq_stat_top sdh_irq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .card_in(card_in), .card_out(card_out), .xfer_valid(xfer_valid),
  .xfer_bytes(xfer_bytes), .irq(irq), .irq_en(irq_en), .raw_q(raw_q),
  .mask_q(mask_q), .stat_q(stat_q), .remain_q(remain_q)
);

// File: tb/sim_sdh_irq_stat_top.sv
`timescale 1ns/1ps
module sim_sdh_irq_stat_top;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 24;
  localparam logic [2:0] A_CTRL = 3'd0, A_MASK = 3'd1, A_MSTAT = 3'd2,
                         A_RAW = 3'd3, A_STAT = 3'd4, A_BCNT = 3'd5, A_REM = 3'd6;
  localparam logic [31:0] B_DONE = 32'h1 << 3, B_CIN = 32'h1 << 30,
                          B_COUT = 32'h1 << 31, B_PRES = 32'h1 << 8, B_EN = 32'h1 << 4;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic card_in = 1'b0, card_out = 1'b0, xfer_valid = 1'b0;
  logic [CNT_W-1:0] xfer_bytes = '0;
  logic irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdh_irq_stat_top #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .card_in(card_in), .card_out(card_out),
    .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes), .irq(irq)
  );

  task automatic check_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic check_irq(input string tag, input logic exp);
    #1;
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_card(input logic ins, input logic rem);
    @(negedge clk);
    card_in = ins; card_out = rem;
    @(negedge clk);
    card_in = 1'b0; card_out = 1'b0;
  endtask

  task automatic xfer(input int n);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_bytes = CNT_W'(n);
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reg("R8 ctrl", A_CTRL, 0);
    check_reg("R8 mask", A_MASK, 0);
    check_reg("R8 raw", A_RAW, 0);
    check_reg("R8 stat", A_STAT, 0);
    check_reg("R8 remain", A_REM, 0);
    check_irq("R8 irq", 1'b0);
  endtask

  task automatic t_card();
    pulse_card(1'b1, 1'b0);
    check_reg("R4 insert raw", A_RAW, B_CIN);
    check_reg("R4 insert present", A_STAT, B_PRES);
    pulse_card(1'b0, 1'b1);
    check_reg("R4 remove raw", A_RAW, B_COUT);
    check_reg("R4 remove present", A_STAT, 0);
  endtask

  task automatic t_irq();
    wr(A_MASK, B_COUT);
    check_irq("R1 enable off", 1'b0);
    check_reg("R2 masked", A_MSTAT, B_COUT);
    check_reg("R2 raw", A_RAW, B_COUT);
    wr(A_CTRL, B_EN);
    check_reg("R10 ctrl readback", A_CTRL, B_EN);
    check_irq("R1 enable on", 1'b1);
    wr(A_MASK, B_CIN);
    check_irq("R1 masked off", 1'b0);
    check_reg("R2 masked zero", A_MSTAT, 0);
    check_reg("R2 raw kept", A_RAW, B_COUT);
  endtask

  task automatic t_w1c();
    wr(A_RAW, 32'h1);
    check_reg("R3 other bits kept", A_RAW, B_COUT);
    wr(A_RAW, B_COUT);
    check_reg("R3 bit cleared", A_RAW, 0);
  endtask

  task automatic t_count();
    wr(A_BCNT, 100);
    check_reg("R5 remain load", A_REM, 100);
    check_reg("R5 total readback", A_BCNT, 100);
    xfer(40);
    check_reg("R6 partial remain", A_REM, 60);
    check_reg("R6 no early done", A_RAW, 0);
    xfer(60);
    check_reg("R6 exact remain", A_REM, 0);
    check_reg("R6 done set", A_RAW, B_DONE);
    wr(A_MASK, B_DONE);
    check_irq("R1 done irq", 1'b1);
    wr(A_RAW, B_DONE);
    check_irq("R1 irq after clear", 1'b0);
    wr(A_BCNT, 10);
    xfer(25);
    check_reg("R6 saturate remain", A_REM, 0);
    check_reg("R6 saturate done", A_RAW, B_DONE);
    check_reg("R5 total unchanged", A_BCNT, 10);
    wr(A_RAW, 32'hFFFF_FFFF);
  endtask

  task automatic t_stat();
    pulse_card(1'b1, 1'b0);
    wr(A_STAT, 0);
    check_reg("R7 zero write keeps", A_STAT, B_PRES);
    wr(A_STAT, B_PRES);
    check_reg("R7 bit cleared", A_STAT, 0);
    wr(A_RAW, 32'hFFFF_FFFF);
  endtask

  task automatic t_prio();
    wr(A_BCNT, 5);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_RAW; wr_data = B_DONE;
    xfer_valid = 1'b1; xfer_bytes = 5;
    @(negedge clk);
    wr_en = 1'b0; xfer_valid = 1'b0;
    check_reg("R9 set beats clear", A_RAW, B_DONE);
    pulse_card(1'b1, 1'b1);
    check_reg("R9 remove wins raw", A_RAW, B_DONE | B_COUT);
    check_reg("R9 remove wins present", A_STAT, 0);
    wr(A_RAW, 32'hFFFF_FFFF);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_BCNT; wr_data = 50;
    xfer_valid = 1'b1; xfer_bytes = 20;
    @(negedge clk);
    wr_en = 1'b0; xfer_valid = 1'b0;
    check_reg("R9 load beats xfer", A_REM, 50);
    check_reg("R9 no done on load", A_RAW, 0);
  endtask

  task automatic t_ro();
    wr(A_REM, 7);
    check_reg("R10 remain not written", A_REM, 50);
    wr(A_MSTAT, 32'hFFFF_FFFF);
    check_reg("R10 raw untouched", A_RAW, 0);
    check_reg("R10 mask untouched", A_MASK, B_DONE);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_card();
    t_irq();
    t_w1c();
    t_count();
    t_stat();
    t_prio();
    t_ro();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule